// File: doc/BRIEF.md
# Burst-Granular Drop FIFO with Watermark

This block is a staging FIFO that sits between a streaming producer and a memory write path. The producer presents one beat per cycle on `in_valid`/`in_data` and is never stalled. Beats are grouped into bursts of `BURST_BEATS` consecutive accepted beats. Storage is reserved and counted in whole bursts. While the downstream burst writer has no memory buffer free and holds `out_ready` low, the FIFO keeps absorbing bursts until all `DEPTH_BURSTS` slots are taken. The FIFO raises `almost_full` once the slot count reaches `AFULL_BURSTS`, which gives the producer time to stop sending.

When a burst starts while every slot is taken, the FIFO discards that whole burst instead of stalling. Each discarded burst adds one to a saturating counter and sets a sticky overflow flag. On the output side, a burst becomes visible only when its final beat has been written. The burst is then handed out beat by beat, with `out_last` marking its final beat.

The ingress side is a three-state machine:
- `ING_IDLE` waits for the first beat of a burst.
  - On `in_valid`, it goes to `ING_FILL` when a slot is free (the take transition).
  - It goes to `ING_DROP` when no slot is free (the reject transition).
- `ING_FILL` stores beats and returns to `ING_IDLE` on the final beat (the complete transition).
- `ING_DROP` swallows beats and returns to `ING_IDLE` on the final beat (the discard-end transition).

Elaboration stops unless `AFULL_BURSTS` is at least 1 and below `DEPTH_BURSTS`, and `BURST_BEATS` is at least 2.

Top module: `burst_drop_fifo`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, `fill_level`, `out_valid`, `almost_full`, `drop_count` and `overflow` are all 0.
- R2: `fill_level` counts reserved burst slots. It rises by one in the cycle after the first beat of an accepted burst and falls by one in the cycle after the final beat of a burst is taken on the output. It never exceeds `DEPTH_BURSTS`. Bursts keep being accepted while `out_ready` is low, until all slots are taken.
- R3: A partially received burst is never offered on the output. `out_valid` is high exactly when at least one burst has all `BURST_BEATS` beats stored and has not been fully read out. It rises in the cycle after the final beat of the first such burst is accepted.
- R4: `almost_full` is high exactly when `fill_level` is greater than or equal to `AFULL_BURSTS`. There is no hysteresis, so it falls as soon as `fill_level` drops below the threshold.
- R5: If the first beat of a burst arrives while `fill_level` equals `DEPTH_BURSTS`, that beat and the following `BURST_BEATS-1` beats are discarded. This holds even if a slot is freed on the same edge. Later bursts are accepted again once a slot is free.
- R6: Stored beats leave in arrival order, one per cycle with `out_valid` and `out_ready` both high. `out_last` is high on every `BURST_BEATS`-th beat out. While `out_ready` is low, `out_data` holds its value.
- R7: `drop_count` rises by one per discarded burst, in the cycle after that burst's first beat, and saturates at 2^`CNT_W`-1.
- R8: `overflow` sets in the cycle after the first discarded burst begins and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Producer beat present this cycle |
| in_data | input | DATA_W | Producer beat |
| almost_full | output | 1 | Backpressure request to the producer |
| out_valid | output | 1 | A beat of a complete burst is offered |
| out_ready | input | 1 | Burst writer takes the offered beat |
| out_data | output | DATA_W | Offered beat |
| out_last | output | 1 | Offered beat is the final beat of its burst |
| fill_level | output | $clog2(DEPTH_BURSTS+1) | Reserved burst slots |
| drop_count | output | CNT_W | Saturating count of discarded bursts |
| overflow | output | 1 | Sticky: a burst was discarded |

## Verification
Two situations are hard to reach from the ports:
- The first beat of a new burst lands on the very edge where the last beat of the oldest burst leaves a full FIFO.
- The drop counter reaches saturation.

To reach the first, the stimulus fills every slot with `out_ready` low. It then toggles `out_ready` at random while bursts with random gaps keep arriving, so slot release and burst starts collide many times. To reach the second, it holds the FIFO full and streams a few hundred back-to-back bursts. A behavioural model built from queues follows every edge and is compared each cycle.

// File: rtl/bdf_pkg.sv
package bdf_pkg;
    typedef enum logic [1:0] {
        ING_IDLE,
        ING_FILL,
        ING_DROP
    } ing_state_t;
endpackage

// File: rtl/bdf_beat_ram.sv
module bdf_beat_ram #(
    parameter int DATA_W  = 16,
    parameter int ENTRIES = 48,
    parameter int ADDR_W  = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [ENTRIES];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/bdf_ingress_fsm.sv
module bdf_ingress_fsm
    import bdf_pkg::*;
#(
    parameter int BURST_BEATS = 4,
    parameter int ENTRIES     = 48,
    parameter int ADDR_W      = 6,
    parameter int BEAT_W      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              slots_full,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              slot_take,
    output logic              burst_done,
    output logic              drop_start
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_BEATS - 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(ENTRIES - 1);

    ing_state_t        state, state_nx;
    logic [BEAT_W-1:0] beat_cnt, beat_nx;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ING_IDLE;
            beat_cnt <= '0;
            wr_addr  <= '0;
        end else begin
            state    <= state_nx;
            beat_cnt <= beat_nx;
            if (wr_en) wr_addr <= (wr_addr == LAST_ADDR) ? '0 : wr_addr + 1'b1;
        end
    end

    // next state and strobes
    always_comb begin
        state_nx   = state;
        beat_nx    = beat_cnt;
        wr_en      = 1'b0;
        slot_take  = 1'b0;
        burst_done = 1'b0;
        drop_start = 1'b0;
        unique case (state)
            ING_IDLE: begin
                if (in_valid) begin
                    beat_nx = BEAT_W'(1);
                    if (slots_full) begin
                        drop_start = 1'b1;
                        state_nx   = ING_DROP;
                    end else begin
                        wr_en     = 1'b1;
                        slot_take = 1'b1;
                        state_nx  = ING_FILL;
                    end
                end
            end
            ING_FILL: begin
                if (in_valid) begin
                    wr_en = 1'b1;
                    if (beat_cnt == LAST_BEAT) begin
                        burst_done = 1'b1;
                        beat_nx    = '0;
                        state_nx   = ING_IDLE;
                    end else begin
                        beat_nx = beat_cnt + 1'b1;
                    end
                end
            end
            ING_DROP: begin
                if (in_valid) begin
                    if (beat_cnt == LAST_BEAT) begin
                        beat_nx  = '0;
                        state_nx = ING_IDLE;
                    end else begin
                        beat_nx = beat_cnt + 1'b1;
                    end
                end
            end
            default: state_nx = ING_IDLE;
        endcase
    end
endmodule

// File: rtl/bdf_occupancy.sv
module bdf_occupancy #(
    parameter int DEPTH_BURSTS = 12,
    parameter int BURST_BEATS  = 4,
    parameter int ENTRIES      = 48,
    parameter int ADDR_W       = 6,
    parameter int BEAT_W       = 2,
    parameter int LVL_W        = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slot_take,
    input  logic              burst_done,
    input  logic              out_ready,
    output logic [LVL_W-1:0]  level,
    output logic              slots_full,
    output logic              out_valid,
    output logic              out_last,
    output logic [ADDR_W-1:0] rd_addr
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_BEATS - 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(ENTRIES - 1);
    localparam logic [LVL_W-1:0]  FULL_LVL  = LVL_W'(DEPTH_BURSTS);

    logic [LVL_W-1:0]  ready_bursts;
    logic [BEAT_W-1:0] rd_beat;
    logic              fire, release_slot;

    assign out_valid    = (ready_bursts != '0);
    assign out_last     = (rd_beat == LAST_BEAT);
    assign fire         = out_valid && out_ready;
    assign release_slot = fire && out_last;
    assign slots_full   = (level == FULL_LVL);

    always_ff @(posedge clk) begin
        if (rst) begin
            level        <= '0;
            ready_bursts <= '0;
            rd_beat      <= '0;
            rd_addr      <= '0;
        end else begin
            level        <= level + LVL_W'(slot_take) - LVL_W'(release_slot);
            ready_bursts <= ready_bursts + LVL_W'(burst_done) - LVL_W'(release_slot);
            if (fire) begin
                rd_beat <= out_last ? '0 : rd_beat + 1'b1;
                rd_addr <= (rd_addr == LAST_ADDR) ? '0 : rd_addr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bdf_drop_tally.sv
module bdf_drop_tally #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    output logic [CNT_W-1:0] count,
    output logic             sticky
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            sticky <= 1'b0;
        end else if (hit) begin
            sticky <= 1'b1;
            if (count != '1) count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/burst_drop_fifo.sv
module burst_drop_fifo #(
    parameter int DATA_W       = 16,
    parameter int BURST_BEATS  = 4,
    parameter int DEPTH_BURSTS = 12,
    parameter int AFULL_BURSTS = 8,
    parameter int CNT_W        = 8,
    localparam int LVL_W       = $clog2(DEPTH_BURSTS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              almost_full,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic [LVL_W-1:0]  fill_level,
    output logic [CNT_W-1:0]  drop_count,
    output logic              overflow
);
    localparam int ENTRIES = DEPTH_BURSTS * BURST_BEATS;
    localparam int ADDR_W  = $clog2(ENTRIES);
    localparam int BEAT_W  = $clog2(BURST_BEATS);

    generate
        if (AFULL_BURSTS < 1 || AFULL_BURSTS >= DEPTH_BURSTS) begin : g_bad_watermark
            $error("AFULL_BURSTS must lie in 1 .. DEPTH_BURSTS-1");
        end
        if (BURST_BEATS < 2) begin : g_bad_burst
            $error("BURST_BEATS must be at least 2");
        end
    endgenerate

    logic              wr_en, slot_take, burst_done, drop_start, slots_full;
    logic [ADDR_W-1:0] wr_addr, rd_addr;

    bdf_ingress_fsm #(
        .BURST_BEATS(BURST_BEATS), .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .BEAT_W(BEAT_W)
    ) u_ingress (
        .clk(clk), .rst(rst), .in_valid(in_valid), .slots_full(slots_full),
        .wr_en(wr_en), .wr_addr(wr_addr), .slot_take(slot_take),
        .burst_done(burst_done), .drop_start(drop_start)
    );

    bdf_beat_ram #(
        .DATA_W(DATA_W), .ENTRIES(ENTRIES), .ADDR_W(ADDR_W)
    ) u_ram (
        .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(in_data),
        .raddr(rd_addr), .rdata(out_data)
    );

    bdf_occupancy #(
        .DEPTH_BURSTS(DEPTH_BURSTS), .BURST_BEATS(BURST_BEATS), .ENTRIES(ENTRIES),
        .ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .LVL_W(LVL_W)
    ) u_occ (
        .clk(clk), .rst(rst), .slot_take(slot_take), .burst_done(burst_done),
        .out_ready(out_ready), .level(fill_level), .slots_full(slots_full),
        .out_valid(out_valid), .out_last(out_last), .rd_addr(rd_addr)
    );

    bdf_drop_tally #(
        .CNT_W(CNT_W)
    ) u_tally (
        .clk(clk), .rst(rst), .hit(drop_start), .count(drop_count), .sticky(overflow)
    );

    assign almost_full = (fill_level >= LVL_W'(AFULL_BURSTS));
endmodule

// File: rtl/bdf_checks.sv
module bdf_checks #(
    parameter int DATA_W       = 16,
    parameter int DEPTH_BURSTS = 12,
    parameter int CNT_W        = 8,
    parameter int LVL_W        = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic [LVL_W-1:0]  fill_level,
    input logic [CNT_W-1:0]  drop_count,
    input logic              overflow
);
    a_r2_level_bounded: assert property (@(posedge clk) disable iff (rst)
        fill_level <= LVL_W'(DEPTH_BURSTS));

    a_r2_level_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (fill_level <= $past(fill_level) + 1'b1));

    a_r3_valid_needs_slot: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (fill_level != '0));

    a_r6_hold_data: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r5_drop_only_full: assert property (@(posedge clk) disable iff (rst)
        (drop_count != $past(drop_count)) |-> ($past(fill_level) == LVL_W'(DEPTH_BURSTS)));

    a_r7_count_monotonic: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (drop_count >= $past(drop_count)));

    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);
endmodule

bind burst_drop_fifo bdf_checks #(
    .DATA_W(DATA_W), .DEPTH_BURSTS(DEPTH_BURSTS), .CNT_W(CNT_W), .LVL_W(LVL_W)
) u_bdf_checks (
    .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .fill_level(fill_level), .drop_count(drop_count),
    .overflow(overflow)
);

// File: tb/test_burst_drop_fifo.sv
module test_burst_drop_fifo;
    localparam int DW = 16;
    localparam int B  = 4;
    localparam int D  = 12;
    localparam int A  = 8;
    localparam int CW = 8;
    localparam int LW = $clog2(D + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          out_ready = 1'b0;
    logic          almost_full, out_valid, out_last, overflow;
    logic [DW-1:0] out_data;
    logic [LW-1:0] fill_level;
    logic [CW-1:0] drop_count;

    always #2.5 clk = ~clk;

    burst_drop_fifo #(
        .DATA_W(DW), .BURST_BEATS(B), .DEPTH_BURSTS(D), .AFULL_BURSTS(A), .CNT_W(CW)
    ) i_burst_drop_fifo (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .almost_full(almost_full), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last), .fill_level(fill_level),
        .drop_count(drop_count), .overflow(overflow)
    );

    // behavioural reference
    logic [DW-1:0] done_q[$];
    logic [DW-1:0] part_q[$];
    int m_level, m_done, m_mode, m_cnt, m_drops, m_rdbeat;
    bit m_ovf;

    always @(posedge clk) begin
        if (rst) begin
            done_q.delete(); part_q.delete();
            m_level = 0; m_done = 0; m_mode = 0; m_cnt = 0;
            m_drops = 0; m_rdbeat = 0; m_ovf = 0;
        end else begin
            bit rel, take, comp;
            rel = 0; take = 0; comp = 0;
            if (m_done > 0 && out_ready) begin
                void'(done_q.pop_front());
                if (m_rdbeat == B - 1) begin rel = 1; m_rdbeat = 0; end
                else m_rdbeat++;
            end
            if (in_valid) begin
                if (m_mode == 0) begin
                    m_cnt = 1;
                    if (m_level == D) begin
                        m_mode = 2; m_ovf = 1;
                        if (m_drops < (1 << CW) - 1) m_drops++;
                    end else begin
                        m_mode = 1; take = 1; part_q.push_back(in_data);
                    end
                end else if (m_mode == 1) begin
                    part_q.push_back(in_data);
                    if (m_cnt == B - 1) begin
                        comp = 1; m_mode = 0; m_cnt = 0;
                        foreach (part_q[k]) done_q.push_back(part_q[k]);
                        part_q.delete();
                    end else m_cnt++;
                end else begin
                    if (m_cnt == B - 1) begin m_mode = 0; m_cnt = 0; end
                    else m_cnt++;
                end
            end
            m_level = m_level + int'(take) - int'(rel);
            m_done  = m_done + int'(comp) - int'(rel);
        end
    end

    int checks = 0, fails = 0, cycles = 0;
    logic [DW-1:0] next_data = 16'h1000;
    bit done_flag = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        if (rst) return;
        chk("R2 fill_level", fill_level, m_level);
        chk("R3 out_valid", out_valid, m_done > 0);
        chk("R4 almost_full", almost_full, m_level >= A);
        chk("R5 R7 drop_count", drop_count, m_drops);
        chk("R8 overflow", overflow, m_ovf);
        if (m_done > 0) begin
            chk("R6 out_data", out_data, done_q[0]);
            chk("R6 out_last", out_last, m_rdbeat == B - 1);
        end
    endtask

    task automatic step(input bit v, input bit rdy);
        @(negedge clk);
        compare_all();
        in_valid  = v;
        out_ready = rdy;
        if (v) begin in_data = next_data; next_data++; end
    endtask

    task automatic burst(input int gap_pct, input int rdy_pct);
        for (int i = 0; i < B; i++) begin
            while (($urandom % 100) < gap_pct) step(0, ($urandom % 100) < rdy_pct);
            step(1, ($urandom % 100) < rdy_pct);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 fill_level", fill_level, 0);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 almost_full", almost_full, 0);
        chk("R1 drop_count", drop_count, 0);
        chk("R1 overflow", overflow, 0);
        rst = 1'b0;
        // partial bursts with gaps, reader always ready
        for (int n = 0; n < 6; n++) burst(35, 100);
        repeat (10) step(0, 1);
        // fill with reader blocked, two extra bursts must drop
        for (int n = 0; n < D + 2; n++) burst(0, 0);
        repeat (3) step(0, 0);
        chk("R5 level full", fill_level, D);
        chk("R5 two drops", drop_count, 2);
        chk("R8 overflow set", overflow, 1);
        // colliding release and new bursts
        for (int n = 0; n < 40; n++) burst(20, 45);
        // saturate drop counter
        repeat (60) step(0, 0);
        for (int n = 0; n < D + 270; n++) burst(0, 0);
        step(0, 0);
        chk("R7 saturated", drop_count, (1 << CW) - 1);
        // drain
        repeat (80) step(0, 1);
        chk("R2 drained", fill_level, 0);
        chk("R4 low after drain", almost_full, 0);
        // reset again clears sticky state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R1 overflow cleared", overflow, 0);
        chk("R1 drop_count cleared", drop_count, 0);
        rst = 1'b0;
        for (int n = 0; n < 4; n++) burst(10, 70);
        repeat (30) step(0, 1);
        finish_run();
    end
endmodule